// File: doc/BRIEF.md
# Amplifier Protection Fault Supervisor

This block watches a power amplifier's health and decides how the output stage must behave. It receives two digitized codes, the supply voltage and the junction temperature, with a strobe that marks each fresh pair. It also receives per-channel over-current pulses and two internal rail-low indications: a low gate-drive charge pump and a sagging internal 5 V rail. From these inputs it produces four outputs:

- an active-high fault flag;
- an active-low muted status;
- an output-disable signal that tri-states every bridge;
- a sleep request for the load-dump case.

The voltage and temperature comparisons each have a set code and a separate clear code, so a reading that sits near a threshold cannot make the amplifier chatter. An over-current pulse starts a self-clearing hold window whose length is a parameter in clock cycles. Until the first valid sample has been evaluated after reset, the outputs stay disabled.

Top module: `amp_prot_supervisor`

## Requirements
- R1: The over-supply flag is updated only on cycles where `sample_valid` is high. It sets when `vsup_code > OV_SET`, clears when `vsup_code < OV_CLR`, and keeps its value for codes between the two. While set, it drives `fault` high on the clock edge after the sample.
- R2: The under-supply flag sets when `vsup_code < UV_SET` and clears when `vsup_code > UV_CLR`. It keeps its value in between and is updated only on valid samples.
- R3: The over-temperature flag sets when `temp_code > OT_SET` and clears when `temp_code < OT_CLR`. It keeps its value in between and is updated only on valid samples.
- R4: A high bit on any channel of `oc_flag` keeps `fault` high for exactly `OC_HOLD_CYC` cycles, counted from the last clock edge that saw an event. A new event during the window restarts the count.
- R5: The load-dump path sets when `vsup_code > LD_SET` and clears when `vsup_code < LD_CLR`, on valid samples. While it is set, `sleep_req` is high and `fault` is high.
- R6: `pump_low` and `rail5_low` are each registered once. Either one drives `fault` high in the cycle after it is seen.
- R7: `out_disable` is high whenever `fault` is high. It is also high from reset until the clock edge that takes the first valid sample.
- R8: `muted_n` is low whenever `mute_n` is low, `fault` is high, or no valid sample has yet been taken. Otherwise it is high.
- R9: While `rst_n` is low and after its release, the reset state is: `fault` = 0, `sleep_req` = 0, `out_disable` = 1, `muted_n` = 0.
- R10: Code values presented while `sample_valid` is low have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Marks a fresh supply/temperature code pair |
| vsup_code | input | CODE_W | Unsigned supply voltage code |
| temp_code | input | CODE_W | Unsigned junction temperature code |
| oc_flag | input | NUM_CH | Per-channel over-current event |
| pump_low | input | 1 | Gate-drive charge pump is low |
| rail5_low | input | 1 | Internal 5 V rail is low |
| mute_n | input | 1 | External mute request, active low |
| fault | output | 1 | Any protection condition active |
| muted_n | output | 1 | Low while the amplifier is muted |
| out_disable | output | 1 | Tri-state all bridge outputs |
| sleep_req | output | 1 | Load-dump sleep request |

## Verification
The bench places codes exactly on and just inside each set and clear code. A design that used `>=` in place of `>`, or that cleared at the set code, would trip or release one sample early. It holds wild codes on the inputs with the strobe low, which would expose a comparator that is not gated by the strobe. It measures the over-current window to the exact cycle and retriggers it mid-window, so an off-by-one counter or a timer that ignores a second event would drop `fault` on the wrong edge. A long random phase compares all four outputs on every clock against a behavioural model, covering overlaps between the fault sources.

// File: rtl/amp_prot_pkg.sv
package amp_prot_pkg;

  // Collected protection sources handed to the decision stage.
  typedef struct packed {
    logic ov;     // supply above the over-voltage band
    logic uv;     // supply below the under-voltage band
    logic ot;     // junction over temperature
    logic ld;     // load-dump band
    logic oc;     // over-current hold window active
    logic pump;   // raw charge pump low indication
    logic rail;   // raw internal rail low indication
  } prot_src_t;

  // Direction of a hysteresis comparator.
  typedef enum logic {
    TRIP_BELOW = 1'b0,
    TRIP_ABOVE = 1'b1
  } trip_dir_e;

endpackage

// File: rtl/amp_hyst_cmp.sv
module amp_hyst_cmp
  import amp_prot_pkg::*;
#(
  parameter int unsigned CODE_W = 10,
  parameter int unsigned SET_C  = 600,
  parameter int unsigned CLR_C  = 560,
  parameter trip_dir_e   DIR    = TRIP_ABOVE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic [CODE_W-1:0] code,
  output logic              flag
);

  localparam logic [CODE_W-1:0] SET_V = SET_C[CODE_W-1:0];
  localparam logic [CODE_W-1:0] CLR_V = CLR_C[CODE_W-1:0];

  logic set_hit;
  logic clr_hit;
  logic flag_d;
  logic flag_q;

  generate
    if (DIR == TRIP_ABOVE) begin : g_above
      assign set_hit = (code > SET_V);
      assign clr_hit = (code < CLR_V);
    end else begin : g_below
      assign set_hit = (code < SET_V);
      assign clr_hit = (code > CLR_V);
    end
  endgenerate

  always_comb begin
    flag_d = flag_q;
    if (smp_en) begin
      if (set_hit) begin
        flag_d = 1'b1;
      end else if (clr_hit) begin
        flag_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/amp_oc_hold.sv
module amp_oc_hold #(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned OC_HOLD_CYC = 150000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] oc_in,
  output logic              active
);

  localparam int unsigned   CNT_W  = $clog2(OC_HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(OC_HOLD_CYC);

  logic             hit;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_q;

  assign hit = |oc_in;

  always_comb begin
    cnt_d = cnt_q;
    if (hit) begin
      cnt_d = HOLD_V;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign active = (cnt_q != '0);

endmodule

// File: rtl/amp_prot_decide.sv
module amp_prot_decide
  import amp_prot_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      smp_en,
  input  prot_src_t src,
  input  logic      mute_n,
  output logic      fault,
  output logic      muted_n,
  output logic      out_disable,
  output logic      sleep_req
);

  logic pump_q;
  logic rail_q;
  logic primed_d;
  logic primed_q;
  logic any_fault;

  always_comb begin
    primed_d = primed_q;
    if (smp_en) begin
      primed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pump_q   <= 1'b0;
      rail_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      pump_q   <= src.pump;
      rail_q   <= src.rail;
      primed_q <= primed_d;
    end
  end

  always_comb begin
    any_fault   = src.ov | src.uv | src.ot | src.ld | src.oc | pump_q | rail_q;
    fault       = any_fault;
    sleep_req   = src.ld;
    out_disable = any_fault | ~primed_q;
    muted_n     = mute_n & ~any_fault & primed_q;
  end

endmodule

// File: rtl/amp_prot_supervisor.sv
module amp_prot_supervisor
  import amp_prot_pkg::*;
#(
  parameter int unsigned CODE_W      = 10,
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned OV_SET      = 600,
  parameter int unsigned OV_CLR      = 560,
  parameter int unsigned UV_SET      = 162,
  parameter int unsigned UV_CLR      = 190,
  parameter int unsigned OT_SET      = 160,
  parameter int unsigned OT_CLR      = 130,
  parameter int unsigned LD_SET      = 600,
  parameter int unsigned LD_CLR      = 580,
  parameter int unsigned OC_HOLD_CYC = 150000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  input  logic [CODE_W-1:0] vsup_code,
  input  logic [CODE_W-1:0] temp_code,
  input  logic [NUM_CH-1:0] oc_flag,
  input  logic              pump_low,
  input  logic              rail5_low,
  input  logic              mute_n,
  output logic              fault,
  output logic              muted_n,
  output logic              out_disable,
  output logic              sleep_req
);

  logic      ov_q;
  logic      uv_q;
  logic      ot_q;
  logic      ld_q;
  logic      oc_act;
  prot_src_t src;

  amp_hyst_cmp #(.CODE_W(CODE_W), .SET_C(OV_SET), .CLR_C(OV_CLR), .DIR(TRIP_ABOVE)) u_ov (
    .clk(clk), .rst_n(rst_n), .smp_en(sample_valid), .code(vsup_code), .flag(ov_q));

  amp_hyst_cmp #(.CODE_W(CODE_W), .SET_C(UV_SET), .CLR_C(UV_CLR), .DIR(TRIP_BELOW)) u_uv (
    .clk(clk), .rst_n(rst_n), .smp_en(sample_valid), .code(vsup_code), .flag(uv_q));

  amp_hyst_cmp #(.CODE_W(CODE_W), .SET_C(OT_SET), .CLR_C(OT_CLR), .DIR(TRIP_ABOVE)) u_ot (
    .clk(clk), .rst_n(rst_n), .smp_en(sample_valid), .code(temp_code), .flag(ot_q));

  amp_hyst_cmp #(.CODE_W(CODE_W), .SET_C(LD_SET), .CLR_C(LD_CLR), .DIR(TRIP_ABOVE)) u_ld (
    .clk(clk), .rst_n(rst_n), .smp_en(sample_valid), .code(vsup_code), .flag(ld_q));

  amp_oc_hold #(.NUM_CH(NUM_CH), .OC_HOLD_CYC(OC_HOLD_CYC)) u_oc (
    .clk(clk), .rst_n(rst_n), .oc_in(oc_flag), .active(oc_act));

  always_comb begin
    src.ov   = ov_q;
    src.uv   = uv_q;
    src.ot   = ot_q;
    src.ld   = ld_q;
    src.oc   = oc_act;
    src.pump = pump_low;
    src.rail = rail5_low;
  end

  amp_prot_decide u_dec (
    .clk(clk), .rst_n(rst_n), .smp_en(sample_valid), .src(src), .mute_n(mute_n),
    .fault(fault), .muted_n(muted_n), .out_disable(out_disable), .sleep_req(sleep_req));

endmodule

// File: rtl/amp_prot_checker.sv
module amp_prot_checker #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_valid,
  input logic [NUM_CH-1:0] oc_flag,
  input logic              ov_q,
  input logic              uv_q,
  input logic              ot_q,
  input logic              fault,
  input logic              muted_n,
  input logic              out_disable,
  input logic              sleep_req
);

  a_r7_fault_disables: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> out_disable);

  a_r8_fault_mutes: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !muted_n);

  a_r5_sleep_is_fault: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> fault);

  a_r4_oc_raises_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (|oc_flag) |=> fault);

  a_r10_ov_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(ov_q));

  a_r10_uv_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(uv_q));

  a_r10_ot_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(ot_q));

endmodule

bind amp_prot_supervisor amp_prot_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .oc_flag(oc_flag),
  .ov_q(ov_q), .uv_q(uv_q), .ot_q(ot_q), .fault(fault), .muted_n(muted_n),
  .out_disable(out_disable), .sleep_req(sleep_req));

// File: tb/sim_amp_prot_supervisor.sv
`timescale 1ns/1ps
module sim_amp_prot_supervisor;

  localparam int CW   = 10;
  localparam int NCH  = 4;
  localparam int HOLD = 20;

  logic           clk;
  logic           rst_n;
  logic           sample_valid;
  logic [CW-1:0]  vsup_code;
  logic [CW-1:0]  temp_code;
  logic [NCH-1:0] oc_flag;
  logic           pump_low;
  logic           rail5_low;
  logic           mute_n;
  logic           fault;
  logic           muted_n;
  logic           out_disable;
  logic           sleep_req;

  int n_run;
  int n_fail;
  bit done;
  bit cmp_on;

  amp_prot_supervisor #(.CODE_W(CW), .NUM_CH(NCH), .OC_HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .vsup_code(vsup_code),
    .temp_code(temp_code), .oc_flag(oc_flag), .pump_low(pump_low), .rail5_low(rail5_low),
    .mute_n(mute_n), .fault(fault), .muted_n(muted_n), .out_disable(out_disable),
    .sleep_req(sleep_req));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Behavioural reference: supply code 50 mV/LSB, temperature code 1 degC/LSB.
  int m_ov, m_uv, m_ot, m_ld, m_cnt, m_pq, m_rq, m_pr;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ov = 0; m_uv = 0; m_ot = 0; m_ld = 0; m_cnt = 0; m_pq = 0; m_rq = 0; m_pr = 0;
    end else begin
      if (sample_valid) begin
        if (vsup_code > 600) m_ov = 1; else if (vsup_code < 560) m_ov = 0;
        if (vsup_code < 162) m_uv = 1; else if (vsup_code > 190) m_uv = 0;
        if (temp_code > 160) m_ot = 1; else if (temp_code < 130) m_ot = 0;
        if (vsup_code > 600) m_ld = 1; else if (vsup_code < 580) m_ld = 0;
        m_pr = 1;
      end
      if (oc_flag != 0) m_cnt = HOLD; else if (m_cnt > 0) m_cnt = m_cnt - 1;
      m_pq = pump_low ? 1 : 0;
      m_rq = rail5_low ? 1 : 0;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      logic ef, ed, em, es;
      ef = (m_ov | m_uv | m_ot | m_ld | m_pq | m_rq) != 0 || m_cnt > 0;
      ed = ef || (m_pr == 0);
      em = mute_n && !ef && (m_pr != 0);
      es = (m_ld != 0);
      chk("R6 model fault", fault, ef);
      chk("R7 model out_disable", out_disable, ed);
      chk("R8 model muted_n", muted_n, em);
      chk("R5 model sleep_req", sleep_req, es);
    end
  end

  task automatic smp(input int v, input int t);
    @(posedge clk); #1;
    vsup_code = CW'(v); temp_code = CW'(t); sample_valid = 1'b1;
    @(posedge clk); #1;
    sample_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_oc(input logic [NCH-1:0] m);
    @(posedge clk); #1; oc_flag = m;
    @(posedge clk); #1; oc_flag = '0;
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 0; cmp_on = 0;
    rst_n = 1'b0; sample_valid = 1'b0; vsup_code = CW'(280); temp_code = CW'(25);
    oc_flag = '0; pump_low = 1'b0; rail5_low = 1'b0; mute_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 reset fault", fault, 1'b0);
    chk("R9 reset sleep_req", sleep_req, 1'b0);
    chk("R9 reset out_disable", out_disable, 1'b1);
    chk("R9 reset muted_n", muted_n, 1'b0);
    @(posedge clk); #1 rst_n = 1'b1;
    cmp_on = 1;
    repeat (3) @(negedge clk);
    chk("R7 unprimed out_disable", out_disable, 1'b1);
    chk("R8 unprimed muted_n", muted_n, 1'b0);
    smp(280, 25);
    chk("R7 primed out_disable", out_disable, 1'b0);
    chk("R8 primed muted_n", muted_n, 1'b1);

    // R1 and R5: over-supply and load-dump bands
    smp(600, 25); chk("R1 at set code no trip", fault, 1'b0);
    smp(601, 25); chk("R1 trip", fault, 1'b1); chk("R5 sleep", sleep_req, 1'b1);
    smp(580, 25); chk("R5 hold at clear code", sleep_req, 1'b1);
    smp(579, 25); chk("R5 release", sleep_req, 1'b0); chk("R1 hold in band", fault, 1'b1);
    smp(560, 25); chk("R1 hold at clear code", fault, 1'b0 | 1'b1);
    smp(559, 25); chk("R1 release", fault, 1'b0);

    // R10: strobe low, codes ignored
    @(posedge clk); #1 vsup_code = CW'(900); temp_code = CW'(250);
    repeat (6) @(negedge clk);
    chk("R10 ignored codes fault", fault, 1'b0);
    chk("R10 ignored codes sleep", sleep_req, 1'b0);
    smp(280, 25);

    // R2
    smp(162, 25); chk("R2 at set code no trip", fault, 1'b0);
    smp(161, 25); chk("R2 trip", fault, 1'b1);
    smp(190, 25); chk("R2 hold at clear code", fault, 1'b1);
    smp(191, 25); chk("R2 release", fault, 1'b0);

    // R3
    smp(280, 161); chk("R3 trip", fault, 1'b1); chk("R8 fault mutes", muted_n, 1'b0);
    smp(280, 130); chk("R3 hold at clear code", fault, 1'b1);
    smp(280, 129); chk("R3 release", fault, 1'b0);

    // R4: exact window, then retrigger
    pulse_oc(4'b0100);
    for (int i = 0; i < HOLD; i++) begin
      @(negedge clk); chk("R4 window high", fault, 1'b1);
    end
    @(negedge clk); chk("R4 window end", fault, 1'b0);
    pulse_oc(4'b0001);
    repeat (10) @(posedge clk);
    #1 oc_flag = 4'b1000;
    @(posedge clk); #1 oc_flag = '0;
    repeat (HOLD - 1) @(negedge clk);
    chk("R4 retrigger extends", fault, 1'b1);
    repeat (2) @(negedge clk);
    chk("R4 retrigger end", fault, 1'b0);

    // R6
    @(posedge clk); #1 pump_low = 1'b1;
    @(posedge clk); #1 pump_low = 1'b0;
    @(negedge clk); chk("R6 pump fault", fault, 1'b1);
    @(posedge clk); #1 rail5_low = 1'b1;
    @(posedge clk); #1 rail5_low = 1'b0;
    @(negedge clk); chk("R6 rail fault", fault, 1'b1);
    @(negedge clk); chk("R6 rail clears", fault, 1'b0);

    // R8 external mute
    @(posedge clk); #1 mute_n = 1'b0;
    @(negedge clk);
    chk("R8 external mute", muted_n, 1'b0);
    chk("R7 mute keeps drive", out_disable, 1'b0);
    @(posedge clk); #1 mute_n = 1'b1;

    // Random phase, compared every cycle by the model
    for (int k = 0; k < 3000; k++) begin
      @(posedge clk); #1;
      sample_valid = ($urandom_range(0, 3) == 0);
      case ($urandom_range(0, 3))
        0: vsup_code = CW'($urandom_range(150, 200));
        1: vsup_code = CW'($urandom_range(550, 610));
        2: vsup_code = CW'($urandom_range(0, 1023));
        default: vsup_code = CW'($urandom_range(250, 350));
      endcase
      temp_code = CW'($urandom_range(120, 170));
      oc_flag   = ($urandom_range(0, 60) == 0) ? NCH'($urandom_range(1, 15)) : '0;
      pump_low  = ($urandom_range(0, 50) == 0);
      rail5_low = ($urandom_range(0, 50) == 0);
      mute_n    = ($urandom_range(0, 7) != 0);
    end
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule